// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block sits between a processor's external-data write port and an on-chip non-volatile byte array, modelled here as a synthesizable RAM. Two software-visible registers steer it: a control register with a write-enable bit, an erase-enable bit and an error-clear bit, and a 4-bit timing prescaler. When the processor writes to the array while writes are enabled, the block either programs one byte or erases the whole 512-byte sector that holds the address. Programming can only clear bits, and erasing sets every byte of the sector to 0xFF.

Each accepted operation is timed by a counter whose length scales with the prescaler code. For that whole time the processor is held by a stall signal. Releasing the stall marks completion, so software never needs to poll. The prescaler code 4'hF is reserved to disable all operations: a write attempt under that code does nothing to the array, does not stall, and raises a sticky error flag. Reads of the array return the stored byte one cycle after the address is presented.

The array size and the timing multipliers are parameters. The default array has 2 KB, which is four sectors, so that elaboration stays small. The sector index is taken from the address bits above bit 8.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, write enable and erase enable read 0, the prescaler reads 4'hF, the error flag reads 0 and `cpu_stall` is low.
- R2: A register write with `reg_sel`=0 loads write enable from `reg_wdata[0]` and erase enable from `reg_wdata[1]`. A register write with `reg_sel`=1 loads the prescaler from `reg_wdata[3:0]`. Each value holds until it is written again.
- R3: With write enable 1, erase enable 0 and prescaler not 4'hF, an idle `cpu_wr` to an address sets that byte to its old value ANDed with `cpu_wdata`, so bits can be cleared but never set.
- R4: With write enable 1 and erase enable 1 and prescaler not 4'hF, an idle `cpu_wr` sets all 512 bytes of the sector holding the address (address bits above bit 8) to 0xFF. The data byte is discarded, and other sectors are unchanged.
- R5: `cpu_stall` rises on the cycle after an accepted write. It stays high for exactly (p+1)·BASE_CYC cycles for a program and (p+1)·BASE_CYC·ERASE_MULT cycles for an erase, where p is the prescaler (defaults 16 and 32).
- R6: With write enable 0, `cpu_wr` leaves the array unchanged and `cpu_stall` stays low.
- R7: With write enable 1 and prescaler 4'hF, `cpu_wr` leaves the array unchanged and does not stall, and the error flag is 1 on the next cycle. The flag stays set until a control-register write with `reg_wdata[7]`=1; a new error in the same cycle wins.
- R8: A `cpu_wr` that arrives while `cpu_stall` is high is dropped. It starts no operation and changes no byte.
- R9: While the block is idle, `cpu_rdata` shows the stored byte at the `cpu_addr` presented on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor data-write strobe into the array space |
| cpu_addr | input | ADDR_W | Array byte address for reads and writes |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Read data, one cycle after the address |
| cpu_stall | output | 1 | High while a timed operation runs |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects prescaler |
| reg_wdata | input | 8 | Register write data |
| ctl_wen | output | 1 | Write-enable bit |
| ctl_een | output | 1 | Erase-enable bit |
| ctl_presc | output | 4 | Prescaler code |
| ctl_err | output | 1 | Sticky disabled-code error flag |

## Verification
The bench reprograms a byte with data that has bits already cleared in the array. A design that writes the new data instead of ANDing it would bring the cleared bits back. It erases one sector after seeding bytes at both of its ends and in the next sector. An off-by-one in the sector base, or a walker that runs past the sector, shows up as a missed byte or a damaged neighbour. Stall lengths are measured for both kinds of operation at several prescaler codes, so a wrong multiplier or a one-cycle timer slip is caught. Writes are also injected mid-stall, with write enable cleared and under the reserved code, to catch a design that accepts them, stalls on them or loses the sticky error.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    localparam logic [3:0] PRESC_OFF = 4'hF;

    typedef struct packed {
        logic       wen;
        logic       een;
        logic [3:0] presc;
        logic       err;
    } ctl_regs_t;

endpackage

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
    import flash_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       err_set,
    output ctl_regs_t  regs_o
);

    ctl_regs_t regs_d, regs_q;
    logic      unused_bits;

    assign unused_bits = ^reg_wdata[6:4];

    always_comb begin
        regs_d = regs_q;
        if (reg_wr && !reg_sel) begin
            regs_d.wen = reg_wdata[0];
            regs_d.een = reg_wdata[1];
            if (reg_wdata[7]) begin
                regs_d.err = 1'b0;
            end
        end
        if (reg_wr && reg_sel) begin
            regs_d.presc = reg_wdata[3:0];
        end
        if (err_set) begin
            regs_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{wen: 1'b0, een: 1'b0, presc: PRESC_OFF, err: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.err && !(reg_wr && !reg_sel && reg_wdata[7]) |=> regs_q.err); // R7

    AST_PRESC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel) |=> $stable(regs_q.presc)); // R2

endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy_o,
    output logic             last_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = load;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;
    assign last_o = tmr_q.busy && (tmr_q.cnt == '0);

    AST_LAST_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start |=> !busy_o); // R5

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !start |=> !busy_o); // R6

endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int SECTOR_W   = 9,
    parameter int BASE_CYC   = 16,
    parameter int ERASE_MULT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_stall,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic              ctl_wen,
    output logic              ctl_een,
    output logic [3:0]        ctl_presc,
    output logic              ctl_err
);

    localparam int MAX_CYC = 16 * BASE_CYC * ERASE_MULT;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [SECTOR_W:0] walk;
    } op_t;

    op_t              op_d, op_q;
    ctl_regs_t        regs;
    logic             busy, last;
    logic             req_idle, accept, err_set;
    logic [CNT_W-1:0] prog_len, erase_len, load;
    logic             arr_we;
    logic [ADDR_W-1:0] arr_waddr, arr_raddr;
    logic [7:0]       arr_wdata, arr_rdata;

    flash_pe_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .err_set   (err_set),
        .regs_o    (regs)
    );

    flash_pe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .load   (load),
        .busy_o (busy),
        .last_o (last)
    );

    flash_pe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    always_comb begin
        req_idle  = cpu_wr && !busy;
        accept    = req_idle && regs.wen && (regs.presc != PRESC_OFF);
        err_set   = req_idle && regs.wen && (regs.presc == PRESC_OFF);
        prog_len  = (CNT_W'(regs.presc) + CNT_W'(1)) * CNT_W'(BASE_CYC);
        erase_len = prog_len * CNT_W'(ERASE_MULT);
        load      = (regs.een ? erase_len : prog_len) - CNT_W'(1);

        op_d = op_q;
        if (accept) begin
            op_d.kind = regs.een ? OP_ERASE : OP_PROG;
            op_d.addr = cpu_addr;
            op_d.data = cpu_wdata;
            op_d.walk = '0;
        end else if (busy && op_q.kind == OP_ERASE && !op_q.walk[SECTOR_W]) begin
            op_d.walk = op_q.walk + 1'b1;
        end

        arr_raddr = busy ? op_q.addr : cpu_addr;
        arr_we    = 1'b0;
        arr_waddr = op_q.addr;
        arr_wdata = arr_rdata & op_q.data;
        if (op_q.kind == OP_ERASE) begin
            arr_we    = busy && !op_q.walk[SECTOR_W];
            arr_waddr = {op_q.addr[ADDR_W-1:SECTOR_W], op_q.walk[SECTOR_W-1:0]};
            arr_wdata = 8'hFF;
        end else begin
            arr_we    = last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
        end else begin
            op_q <= op_d;
        end
    end

    assign cpu_rdata = arr_rdata;
    assign cpu_stall = busy;
    assign ctl_wen   = regs.wen;
    assign ctl_een   = regs.een;
    assign ctl_presc = regs.presc;
    assign ctl_err   = regs.err;

    AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && !cpu_stall && ctl_wen && ctl_presc != PRESC_OFF |=> cpu_stall); // R5

    AST_DISABLED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && !cpu_stall && !ctl_wen |=> !cpu_stall); // R6

    AST_OFF_CODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && !cpu_stall && ctl_wen && ctl_presc == PRESC_OFF |=> !cpu_stall && ctl_err); // R7

    AST_BUSY_REQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall && cpu_wr |=> $stable(op_q.addr) && $stable(op_q.data)); // R8

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> cpu_stall); // R8

endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;

    localparam int AW   = 11;
    localparam int SW   = 9;
    localparam int BASE = 16;
    localparam int EM   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          cpu_stall;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic          ctl_wen, ctl_een, ctl_err;
    logic [3:0]    ctl_presc;

    always #10 clk = ~clk;

    flash_pe_ctrl #(.ADDR_W(AW), .SECTOR_W(SW), .BASE_CYC(BASE), .ERASE_MULT(EM)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_wen(ctl_wen), .ctl_een(ctl_een), .ctl_presc(ctl_presc), .ctl_err(ctl_err)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    logic [7:0] mmem [0:(1<<AW)-1];
    int         m_cnt;
    bit         m_wen, m_een, m_err, m_erase;
    bit [3:0]   m_presc;
    int         m_addr;
    logic [7:0] m_data;
    logic [7:0] exp_rd;
    bit         rd_ok;

    initial begin
        for (int i = 0; i < (1 << AW); i++) mmem[i] = 'x;
    end

    always @(posedge clk) begin
        bit idle;
        bit seterr;
        if (!rst_n) begin
            m_cnt = 0; m_wen = 0; m_een = 0; m_err = 0; m_presc = 4'hF; rd_ok = 0;
        end else begin
            idle   = (m_cnt == 0);
            seterr = 0;
            rd_ok  = idle;
            exp_rd = mmem[cpu_addr];
            if (!idle) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_erase) begin
                        for (int i = 0; i < (1 << SW); i++)
                            mmem[(m_addr & ~((1 << SW) - 1)) | i] = 8'hFF;
                    end else begin
                        mmem[m_addr] = mmem[m_addr] & m_data;
                    end
                end
            end
            if (idle && cpu_wr && m_wen) begin
                if (m_presc == 4'hF) seterr = 1;
                else begin
                    m_erase = m_een;
                    m_addr  = int'(cpu_addr);
                    m_data  = cpu_wdata;
                    m_cnt   = (int'(m_presc) + 1) * BASE * (m_een ? EM : 1);
                end
            end
            if (reg_wr && !reg_sel) begin
                m_wen = reg_wdata[0];
                m_een = reg_wdata[1];
                if (reg_wdata[7]) m_err = 0;
            end
            if (reg_wr && reg_sel) m_presc = reg_wdata[3:0];
            if (seterr) m_err = 1;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 stall vs model", cpu_stall, (m_cnt > 0));
            chk("R2 wen vs model", ctl_wen, m_wen);
            chk("R2 een vs model", ctl_een, m_een);
            chk("R2 presc vs model", ctl_presc, m_presc);
            chk("R7 err vs model", ctl_err, m_err);
            if (rd_ok && !$isunknown(exp_rd)) chk("R9 rdata vs model", cpu_rdata, exp_rd);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog expired act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wreg(input logic sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cwrite(input logic [AW-1:0] a, input logic [7:0] d, output int len);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        len = 0;
        while (cpu_stall) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic cread(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a;
        @(negedge clk);
        v = cpu_rdata;
    endtask

    initial begin
        int         len;
        logic [7:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wen", ctl_wen, 1'b0);
        chk("R1 een", ctl_een, 1'b0);
        chk("R1 presc", ctl_presc, 4'hF);
        chk("R1 err", ctl_err, 1'b0);
        chk("R1 stall", cpu_stall, 1'b0);

        // R4 R5 erase every sector at prescaler 0
        wreg(1'b1, 8'h00);
        wreg(1'b0, 8'h03);
        chk("R2 wen+een set", {ctl_wen, ctl_een}, 2'b11);
        for (int s = 0; s < (1 << (AW - SW)); s++) begin
            cwrite(AW'(s * 512 + 5), 8'h00, len);
            chk("R5 erase length p=0", len, 512);
        end
        cread(11'h000, v); chk("R4 erased first byte", v, 8'hFF);
        cread(11'h1FF, v); chk("R4 erased last byte of sector", v, 8'hFF);
        cread(11'h7FF, v); chk("R4 erased top byte", v, 8'hFF);
        cread(11'h005, v); chk("R4 erase data ignored", v, 8'hFF);

        // R3 R5 programming at prescaler 2
        wreg(1'b0, 8'h01);
        wreg(1'b1, 8'h02);
        cwrite(11'h123, 8'h3C, len);
        chk("R5 program length p=2", len, 48);
        cread(11'h123, v); chk("R3 program value", v, 8'h3C);
        cwrite(11'h123, 8'hF0, len);
        cread(11'h123, v); chk("R3 bits only clear", v, 8'h30);

        // R8 a write during stall is dropped
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 11'h130; cpu_wdata = 8'h0F;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 11'h124; cpu_wdata = 8'h00;
        @(negedge clk);
        cpu_wr = 1'b0;
        while (cpu_stall) @(negedge clk);
        cread(11'h124, v); chk("R8 mid-stall write dropped", v, 8'hFF);
        cread(11'h130, v); chk("R8 first write kept", v, 8'h0F);

        // R6 write enable clear
        wreg(1'b0, 8'h00);
        cwrite(11'h200, 8'h00, len);
        chk("R6 no stall", len, 0);
        cread(11'h200, v); chk("R6 array unchanged", v, 8'hFF);

        // R7 reserved prescaler code
        wreg(1'b0, 8'h01);
        wreg(1'b1, 8'hFF);
        cwrite(11'h300, 8'h00, len);
        chk("R7 no stall", len, 0);
        chk("R7 err set", ctl_err, 1'b1);
        cread(11'h300, v); chk("R7 array unchanged", v, 8'hFF);
        wreg(1'b0, 8'h01);
        chk("R7 err sticky", ctl_err, 1'b1);
        wreg(1'b0, 8'h81);
        chk("R7 err cleared", ctl_err, 1'b0);

        // R4 sector-local erase at prescaler 1
        wreg(1'b1, 8'h00);
        cwrite(11'h400, 8'h55, len);
        cwrite(11'h5FF, 8'h0F, len);
        cwrite(11'h600, 8'h11, len);
        cwrite(11'h3FF, 8'h22, len);
        wreg(1'b1, 8'h01);
        wreg(1'b0, 8'h03);
        cwrite(11'h4A0, 8'h00, len);
        chk("R5 erase length p=1", len, 1024);
        cread(11'h400, v); chk("R4 sector base erased", v, 8'hFF);
        cread(11'h5FF, v); chk("R4 sector end erased", v, 8'hFF);
        cread(11'h600, v); chk("R4 next sector kept", v, 8'h11);
        cread(11'h3FF, v); chk("R4 previous sector kept", v, 8'h22);

        // R2 register field loading
        wreg(1'b0, 8'h02);
        chk("R2 wen clear", ctl_wen, 1'b0);
        chk("R2 een set", ctl_een, 1'b1);
        wreg(1'b1, 8'hA7);
        chk("R2 presc low nibble", ctl_presc, 4'h7);

        // R3 R9 mixed programming with a wandering read address
        wreg(1'b1, 8'h00);
        wreg(1'b0, 8'h01);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cpu_wr = 1'b1;
            cpu_addr = AW'($urandom_range(0, 1023));
            cpu_wdata = 8'($urandom);
            @(negedge clk);
            cpu_wr = 1'b0;
            while (cpu_stall) @(negedge clk);
            repeat (3) begin
                cpu_addr = AW'($urandom_range(0, 1023));
                @(negedge clk);
            end
        end

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule